// File: doc/BRIEF.md
# Debug Trigger and Break Controller

This block watches the CPU bus on behalf of an on-chip debugger. An 8-bit control register, written over a simple register bus, enables it and arms a debug run. Two address comparators then look for bus accesses. Each comparator can optionally be limited to read cycles or to write cycles. Every access that hits a comparator during a run is pushed into a small trace FIFO. The run ends with an optional single-cycle break request to the CPU, and that request is either a tag request or a force request.

A run can end in one of two ways, chosen by the trace mode input. In end-trace mode the run finishes on the first qualifying hit, and the break fires for that hit. In begin-trace mode the run goes on collecting hits and finishes when the FIFO becomes full, with the break issued at that point. When a run finishes, hardware clears the arm bit. Software can also stop a run at any time by writing 0 to the arm bit or to the enable bit. While the security input is high, the enable bit can never be written to 1.

The trace contents are read back through the same register bus. Reading the trace location returns the oldest stored address and removes it from the FIFO.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00 and brk_req, brk_tag, armed, trace_full and trace_cnt are all 0.
- R2: A control write made while secure_i is 1 leaves the enable bit (bit 7) at 0. The other bits are stored as written.
- R3: Writing the control register (reg_addr 0) with bit 6 (arm) = 1 sets the arm bit and the armed output, and empties the trace FIFO (trace_cnt becomes 0).
- R4: A run is active when bit 7 and bit 6 are both 1. Comparator A uses reg_addr 1 and control bits 3 (direction value) and 2 (direction enable). Comparator B uses reg_addr 2 and bits 1 and 0. A comparator hits on a valid access whose address equals its register. When its direction enable is 1, it also requires bus_rd to equal its direction value (1 = read, 0 = write). An access to any other address never hits.
- R5: During a break pulse, brk_tag equals control bit 5 (1 = tag request, 0 = force request). brk_tag is 0 whenever there is no pulse.
- R6: When break enable (bit 4) is 0, a run never produces brk_req, but hits are still stored and the run still completes.
- R7: In end-trace mode (trace_mode = 0), the first hit of a run raises brk_req for exactly one cycle, on the edge that samples the hit. The same edge clears the arm bit and the armed output.
- R8: In begin-trace mode (trace_mode = 1), brk_req fires and the arm bit clears on the edge that stores the DEPTH-th entry. From then on trace_full = 1 and trace_cnt = DEPTH.
- R9: The FIFO stores hit addresses in the order they occur. A read of reg_addr 3 returns the oldest entry and removes it. A push into a full FIFO is dropped.
- R10: After a write that leaves bit 6 or bit 7 at 0, later accesses are neither stored nor cause a break.
- R11: The control register and both comparator registers can be written and read back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 control, 1 comparator A, 2 comparator B, 3 trace head (read pops) |
| reg_wdata | input | AW | Register write data (control uses bits 7:0) |
| reg_rdata | output | AW | Registered read data, valid the cycle after reg_rd |
| secure_i | input | 1 | Device secured; blocks setting enable |
| bus_addr | input | AW | CPU bus address |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_vld | input | 1 | CPU bus access valid |
| trace_mode | input | 1 | 0 = end trace, 1 = begin trace |
| brk_req | output | 1 | Single-cycle CPU break request |
| brk_tag | output | 1 | Break type during the pulse: 1 tag, 0 force |
| armed | output | 1 | Armed status flag |
| trace_full | output | 1 | Trace FIFO holds DEPTH entries |
| trace_cnt | output | $clog2(DEPTH+1) | Trace FIFO occupancy |

## Verification
Every result comes from a register, so each stimulus shows up one clock edge after the cycle in which it was presented. This holds for a bus access, a register write, and a read strobe. Break pulses, FIFO occupancy, the armed flag and the read data all follow this rule. The bench drives inputs on the falling edge and holds them for one cycle. It then samples on the next falling edge, which comes after exactly one rising edge, so a single-cycle break pulse is caught in the only half-period in which it can be seen. Comparator qualification is swept over every combination of direction enable, direction value, access direction and comparator. Begin-trace fills are checked entry by entry, including the occupancy after each access.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int CTRL_W = 8;
  localparam int NCMP   = 2;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_CMPA  = 2'd1,
    RA_CMPB  = 2'd2,
    RA_TRACE = 2'd3
  } reg_addr_e;

  typedef enum logic {
    TM_END   = 1'b0,
    TM_BEGIN = 1'b1
  } trace_mode_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic en;
    logic arm;
    logic tag;
    logic brk_en;
    logic rwa_val;
    logic rwa_en;
    logic rwb_val;
    logic rwb_en;
  } ctrl_t;
endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_vld,
  input  logic [AW-1:0] ref_addr,
  input  logic          dir_en,
  input  logic          dir_val,
  output logic          hit
);
  logic dir_ok;

  always_comb begin
    dir_ok = !dir_en || (bus_rd == dir_val);
    hit    = bus_vld && (bus_addr == ref_addr) && dir_ok;
  end
endmodule

// File: rtl/dbg_trace_fifo.sv
module dbg_trace_fifo #(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [AW-1:0]                din,
  input  logic                         pop,
  output logic [AW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign cnt     = cnt_q;
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && (cnt_q != '0) && !clr;
  assign dout    = mem[rd_ptr_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic                       reg_rd,
  input  logic [1:0]                 reg_addr,
  input  logic [AW-1:0]              reg_wdata,
  output logic [AW-1:0]              reg_rdata,
  input  logic                       secure_i,
  input  logic [AW-1:0]              bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_vld,
  input  logic                       trace_mode,
  output logic                       brk_req,
  output logic                       brk_tag,
  output logic                       armed,
  output logic                       trace_full,
  output logic [$clog2(DEPTH+1)-1:0] trace_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  ctrl_t         ctrl_q, wr_ctrl;
  logic [AW-1:0] cmp_q [NCMP];
  logic [NCMP-1:0] hit, dir_en, dir_val;
  logic          armf_q;
  logic          ctrl_wr, pop_req, running, ev, fill_last, done;
  logic [AW-1:0] fifo_dout;

  assign wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign pop_req = reg_rd && (reg_addr == RA_TRACE);
  assign running = ctrl_q.en && ctrl_q.arm;

  assign dir_en  = {ctrl_q.rwb_en,  ctrl_q.rwa_en};
  assign dir_val = {ctrl_q.rwb_val, ctrl_q.rwa_val};

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    dbg_addr_cmp #(.AW(AW)) u_cmp (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_vld  (bus_vld),
      .ref_addr (cmp_q[g]),
      .dir_en   (dir_en[g]),
      .dir_val  (dir_val[g]),
      .hit      (hit[g])
    );
  end

  assign ev        = running && !ctrl_wr && (|hit);
  assign fill_last = (trace_cnt == CW'(DEPTH - 1)) && !pop_req;
  assign done      = ev && ((trace_mode_e'(trace_mode) == TM_END) || fill_last);

  dbg_trace_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_wr && wr_ctrl.arm),
    .push (ev),
    .din  (bus_addr),
    .pop  (pop_req),
    .dout (fifo_dout),
    .cnt  (trace_cnt),
    .full (trace_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      armf_q    <= 1'b0;
      brk_req   <= 1'b0;
      brk_tag   <= 1'b0;
      reg_rdata <= '0;
      for (int i = 0; i < NCMP; i++) cmp_q[i] <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q    <= wr_ctrl;
        ctrl_q.en <= wr_ctrl.en && !secure_i;
        armf_q    <= wr_ctrl.arm;
      end else if (done) begin
        ctrl_q.arm <= 1'b0;
        armf_q     <= 1'b0;
      end
      for (int i = 0; i < NCMP; i++)
        if (reg_we && (reg_addr == 2'(i + 1))) cmp_q[i] <= reg_wdata;
      brk_req <= done && ctrl_q.brk_en;
      brk_tag <= done && ctrl_q.brk_en && ctrl_q.tag;
      if (reg_rd) begin
        case (reg_addr_e'(reg_addr))
          RA_CTRL:  reg_rdata <= AW'(ctrl_q);
          RA_CMPA:  reg_rdata <= cmp_q[0];
          RA_CMPB:  reg_rdata <= cmp_q[1];
          default:  reg_rdata <= fifo_dout;
        endcase
      end
    end
  end

  assign armed = armf_q;

  AST_SECURE_EN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && secure_i) |=> !ctrl_q.en); // R2
  AST_TAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !brk_req |-> !brk_tag); // R5
  AST_BRK_GATED: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> ctrl_q.brk_en); // R6
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req); // R7
  AST_BRK_DISARMED: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (!armed && !ctrl_q.arm)); // R7
  AST_STOP_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !(reg_wdata[6] && reg_wdata[7])) |=> !brk_req); // R10
endmodule

// File: tb/dbg_trig_ctrl_tb.sv
module dbg_trig_ctrl_tb;
  localparam int AW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] A_ADR = 8'h3C, B_ADR = 8'h5A, X_ADR = 8'h11;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [AW-1:0] reg_wdata = 0, reg_rdata;
  logic secure_i = 0;
  logic [AW-1:0] bus_addr = 0;
  logic bus_rd = 0, bus_vld = 0, trace_mode = 0;
  logic brk_req, brk_tag, armed, trace_full;
  logic [CW-1:0] trace_cnt;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  dbg_trig_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic acc(input logic [7:0] a, input logic r);
    @(negedge clk); bus_vld = 1; bus_addr = a; bus_rd = r;
    @(negedge clk); bus_vld = 0;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd0, d);
    chk("R1", "ctrl", d, 0);
    chk("R1", "brk", brk_req, 0);
    chk("R1", "armed", armed, 0);
    chk("R1", "cnt", trace_cnt, 0);
    chk("R1", "full", trace_full, 0);

    // R11 readback
    wr(2'd1, A_ADR); wr(2'd2, B_ADR);
    rd(2'd1, d); chk("R11", "cmpA", d, A_ADR);
    rd(2'd2, d); chk("R11", "cmpB", d, B_ADR);
    wr(2'd0, 8'h3F); rd(2'd0, d); chk("R11", "ctrl", d, 8'h3F);
    wr(2'd0, 8'h00);

    // R2 secure blocks enable; R10 arm without enable stores nothing
    secure_i = 1;
    wr(2'd0, 8'hC0);
    rd(2'd0, d); chk("R2", "ctrl while secure", d, 8'h40);
    chk("R3", "armed", armed, 1);
    secure_i = 0;
    acc(A_ADR, 1);
    chk("R10", "cnt without enable", trace_cnt, 0);
    chk("R10", "brk without enable", brk_req, 0);
    wr(2'd0, 8'h00);

    // R4/R5/R7 qualification sweep, end trace
    trace_mode = 0;
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 2; v++)
          for (int r = 0; r < 2; r++) begin
            logic [7:0] cw;
            logic tg, exp_hit;
            tg = (e ^ r);
            cw = 8'hD0 | (8'(tg) << 5);
            if (c == 0) cw = cw | (8'(v) << 3) | (8'(e) << 2);
            else        cw = cw | (8'(v) << 1) | 8'(e);
            exp_hit = !e || (r == v);
            wr(2'd0, cw);
            chk("R3", "cnt after arm", trace_cnt, 0);
            acc(X_ADR, r[0]);
            chk("R4", "miss addr brk", brk_req, 0);
            acc(c == 0 ? A_ADR : B_ADR, r[0]);
            chk("R4", "hit brk", brk_req, exp_hit);
            chk("R5", "brk type", brk_tag, exp_hit & tg);
            chk("R7", "armed after", armed, !exp_hit);
            if (exp_hit) begin
              @(negedge clk);
              chk("R7", "pulse one cycle", brk_req, 0);
            end
            wr(2'd0, 8'h00);
          end

    // R6 break disabled, end trace
    wr(2'd0, 8'hC0);
    acc(A_ADR, 0);
    chk("R6", "no brk", brk_req, 0);
    chk("R6", "stored", trace_cnt, 1);
    chk("R6", "completed", armed, 0);
    rd(2'd0, d); chk("R7", "arm bit cleared", d, 8'h80);

    // R8/R9 begin trace fill
    trace_mode = 1;
    wr(2'd0, 8'hF0);
    for (int i = 0; i < DEPTH; i++) begin
      acc((i % 2) ? B_ADR : A_ADR, i[0]);
      chk("R8", "cnt", trace_cnt, i + 1);
      chk("R8", "brk", brk_req, i == DEPTH - 1);
      chk("R8", "armed", armed, i != DEPTH - 1);
    end
    chk("R8", "full", trace_full, 1);
    chk("R5", "tag", brk_tag, 1);
    acc(A_ADR, 0);
    chk("R9", "no push when done", trace_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd3, d);
      chk("R9", "order", d, (i % 2) ? B_ADR : A_ADR);
      chk("R9", "cnt pop", trace_cnt, DEPTH - 1 - i);
    end

    // R10 stop by arm=0 and by enable=0
    wr(2'd0, 8'hD0);
    acc(A_ADR, 0); acc(B_ADR, 1);
    chk("R10", "cnt before stop", trace_cnt, 2);
    wr(2'd0, 8'h90);
    chk("R10", "armed after stop", armed, 0);
    acc(A_ADR, 0);
    chk("R10", "cnt after arm stop", trace_cnt, 2);
    chk("R10", "brk after arm stop", brk_req, 0);
    wr(2'd0, 8'h50);
    acc(B_ADR, 0);
    chk("R10", "cnt after enable stop", trace_cnt, 0);
    chk("R10", "brk after enable stop", brk_req, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule